// File: doc/BRIEF.md
# Interval Counter Channel, Terminal-Count Mode

This block is a single channel of a programmable interval counter fixed in the mode that raises a flag on terminal count. A host programs it over a narrow byte bus. A select line `addr` chooses between the control port (1) and the count data port (0). A program word drops the terminal-count flag `out_tc` and arms the loader. The 16-bit initial count then arrives as two data-port writes, low byte first. From the next clock the count falls by one on every clock while `gate` is high. `out_tc` rises on the clock at which the count reaches zero.

Once `out_tc` is high it stays high. The count keeps running past zero, wrapping through 0xFFFF, until the host writes a new program word or a new count byte. A latch command captures the running count into a holding register. The host can then read that copy as two stable bytes while the live counter continues. Only binary counting and the low-then-high load format are supported.

Top module: `ivt_channel`

## Requirements
- R1: After reset, `out_tc` is 0, the count is 0, no value is latched, both byte pointers point at the low byte, and a data-port read returns 0x00.
- R2: A control-port write whose access field (wdata bits 5:4) is 11 is a program word. From the next clock `out_tc` is 0, counting stops, and the next data write is taken as the low byte. Bits 7:6 and 3:0 of the word are ignored.
- R3: Data-port writes load the count low byte first, then high byte. Writing the low byte stops counting and drives `out_tc` low. Writing the high byte loads the full 16-bit value.
- R4: Counting starts on the clock after the high byte is written. The count then decreases by exactly one on each clock at which `gate` is 1.
- R5: While `gate` is 0 the count holds its value.
- R6: `out_tc` goes high on the clock at which the count becomes 0. It stays high until a program word or a count byte is written.
- R7: From zero the count wraps to 0xFFFF and keeps decreasing, and `out_tc` does not fall again.
- R8: A control-port write with access field 00 is a latch command. It copies the current count into a holding register and resets the read pointer to the low byte. It leaves `out_tc`, the count and the loader untouched.
- R9: A held value is returned by data-port reads, low byte then high byte, while the live count keeps running. It is released after its high byte is read. Latch commands that arrive while a value is held are ignored.
- R10: With no value held, data-port reads return the live count, alternating low and high byte. A program word resets the read pointer to the low byte. Control-port reads return 0x00.
- R11: Control-port writes with access field 01 or 10 have no effect on the count, `out_tc`, the loader or the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the counting clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock; advances the read pointer |
| addr | input | 1 | 1 selects the control port, 0 the count data port |
| wdata | input | 8 | Write data byte |
| gate | input | 1 | Count enable level |
| rdata | output | 8 | Read data byte for the current `addr` and read pointer |
| out_tc | output | 1 | Terminal-count flag |

## Verification
A wrong count never reaches `out_tc` until terminal count, which may be up to 65536 clocks away. The bench therefore also reads the count bytes and compares both `rdata` and `out_tc` against a behavioural model on every clock. A stuck or skipped decrement then shows within one read. A broken latch shows as a held byte that drifts between the low and the high read. A broken byte pointer shows as swapped bytes on the very next read. An error in the loader's byte order shows as a terminal count at the wrong clock, and also at once on the following readback.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;
  localparam int ACC_LSB = 4;
endpackage

// File: rtl/ivt_bus_dec.sv
module ivt_bus_dec
  import ivt_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [1:0] acc,
  output logic       prog_p,
  output logic       latch_p,
  output logic       dwr_p,
  output logic       drd_p
);
  logic ctl_wr;

  always_comb begin
    ctl_wr  = wr_en && addr;
    prog_p  = ctl_wr && (acc_e'(acc) == ACC_LOHI);
    latch_p = ctl_wr && (acc_e'(acc) == ACC_LATCH);
    dwr_p   = wr_en && !addr;
    drd_p   = rd_en && !addr;
  end
endmodule

// File: rtl/ivt_loader.sv
module ivt_loader #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_p,
  input  logic             dwr_p,
  input  logic [BUS_W-1:0] wdata,
  output logic             load_p,
  output logic             disarm_p,
  output logic [CNT_W-1:0] load_val
);
  localparam int NBYTE = CNT_W / BUS_W;
  localparam int PTR_W = (NBYTE > 1) ? $clog2(NBYTE) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTE - 1);

  logic [PTR_W-1:0] wptr_q, wptr_nx;
  logic [CNT_W-1:0] stage_q, stage_nx;
  logic             stage_en;

  always_comb begin
    load_val = {wdata, stage_q[CNT_W-1:BUS_W]};
    load_p   = dwr_p && (wptr_q == LAST);
    disarm_p = dwr_p && (wptr_q != LAST);
    stage_en = dwr_p;
    stage_nx = load_val;
    wptr_nx  = wptr_q;
    if (prog_p)      wptr_nx = '0;
    else if (load_p) wptr_nx = '0;
    else if (dwr_p)  wptr_nx = wptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      stage_q <= '0;
    end else begin
      wptr_q <= wptr_nx;
      if (stage_en) stage_q <= stage_nx;
    end
  end
endmodule

// File: rtl/ivt_core.sv
module ivt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_p,
  input  logic             disarm_p,
  input  logic             load_p,
  input  logic [CNT_W-1:0] load_val,
  input  logic             gate,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             out_tc
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_nx;
  logic             armed_q, armed_nx;
  logic             out_q, out_nx;

  always_comb begin
    count_nx = count_q;
    armed_nx = armed_q;
    out_nx   = out_q;
    if (prog_p || disarm_p) begin
      armed_nx = 1'b0;
      out_nx   = 1'b0;
    end else if (load_p) begin
      count_nx = load_val;
      armed_nx = 1'b1;
      out_nx   = 1'b0;
    end else if (armed_q && gate) begin
      count_nx = count_q - ONE;
      if (count_q == ONE) out_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      count_q <= count_nx;
      armed_q <= armed_nx;
      out_q   <= out_nx;
    end
  end

  assign count  = count_q;
  assign armed  = armed_q;
  assign out_tc = out_q;
endmodule

// File: rtl/ivt_readback.sv
module ivt_readback #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_p,
  input  logic             latch_p,
  input  logic             drd_p,
  input  logic             sel_ctl,
  input  logic [CNT_W-1:0] count,
  output logic             latched,
  output logic [CNT_W-1:0] lval,
  output logic [BUS_W-1:0] rdata
);
  localparam int NBYTE = CNT_W / BUS_W;
  localparam int PTR_W = (NBYTE > 1) ? $clog2(NBYTE) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTE - 1);

  logic             held_q, held_nx;
  logic [CNT_W-1:0] lval_q;
  logic             cap_en;
  logic [PTR_W-1:0] rptr_q, rptr_nx;
  logic [CNT_W-1:0] src;
  int               sel;

  always_comb begin
    cap_en  = latch_p && !held_q;
    held_nx = held_q;
    rptr_nx = rptr_q;
    if (prog_p) begin
      rptr_nx = '0;
    end else if (cap_en) begin
      held_nx = 1'b1;
      rptr_nx = '0;
    end else if (drd_p) begin
      rptr_nx = (rptr_q == LAST) ? '0 : rptr_q + PTR_W'(1);
      if (rptr_q == LAST) held_nx = 1'b0;
    end
  end

  always_comb begin
    src   = held_q ? lval_q : count;
    sel   = int'(rptr_q) * BUS_W;
    rdata = sel_ctl ? '0 : src[sel +: BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      lval_q <= '0;
      rptr_q <= '0;
    end else begin
      held_q <= held_nx;
      rptr_q <= rptr_nx;
      if (cap_en) lval_q <= count;
    end
  end

  assign latched = held_q;
  assign lval    = lval_q;
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             gate,
  output logic [BUS_W-1:0] rdata,
  output logic             out_tc
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             prog_p, latch_p, dwr_p, drd_p;
  logic             load_p, disarm_p;
  logic [CNT_W-1:0] load_val, count, lval;
  logic             armed, latched;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ivt_bus_dec u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc(wdata[ACC_LSB +: 2]),
    .prog_p(prog_p), .latch_p(latch_p), .dwr_p(dwr_p), .drd_p(drd_p)
  );

  ivt_loader #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_load (
    .clk(clk), .rst_n(rst_n_s), .prog_p(prog_p), .dwr_p(dwr_p),
    .wdata(wdata), .load_p(load_p), .disarm_p(disarm_p), .load_val(load_val)
  );

  ivt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n_s), .prog_p(prog_p), .disarm_p(disarm_p),
    .load_p(load_p), .load_val(load_val), .gate(gate),
    .count(count), .armed(armed), .out_tc(out_tc)
  );

  ivt_readback #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_rb (
    .clk(clk), .rst_n(rst_n_s), .prog_p(prog_p), .latch_p(latch_p),
    .drd_p(drd_p), .sel_ctl(addr), .count(count),
    .latched(latched), .lval(lval), .rdata(rdata)
  );
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_p,
  input logic             load_p,
  input logic             disarm_p,
  input logic             gate,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic             out_tc,
  input logic             latched,
  input logic [CNT_W-1:0] lval
);
  // R2
  prog_drops_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_p |=> (!out_tc && !armed));

  // R4
  dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && gate && !prog_p && !load_p && !disarm_p) |=>
      (count == $past(count) - CNT_W'(1)));

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !load_p) |=> $stable(count));

  // R6
  out_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tc && !prog_p && !load_p && !disarm_p) |=> out_tc);

  // R6
  out_rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_tc) |-> (count == '0));

  // R9
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> $stable(lval));
endmodule

bind ivt_channel ivt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .prog_p(prog_p), .load_p(load_p),
  .disarm_p(disarm_p), .gate(gate), .armed(armed), .count(count),
  .out_tc(out_tc), .latched(latched), .lval(lval)
);

// File: tb/sim_ivt_channel.sv
module sim_ivt_channel;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, gate = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       out_tc;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference state
  logic [15:0] m_cnt, m_lval;
  logic [7:0]  m_lo;
  bit m_out, m_arm, m_held, m_wsecond, m_rhigh;
  int rel = 0;

  always #5 clk = ~clk;

  ivt_channel u0 (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .gate(gate), .rdata(rdata), .out_tc(out_tc)
  );

  task automatic m_reset();
    m_cnt = 16'h0; m_lval = 16'h0; m_lo = 8'h0;
    m_out = 0; m_arm = 0; m_held = 0; m_wsecond = 0; m_rhigh = 0;
  endtask

  always @(posedge clk) begin
    if (!arst_n) begin rel = 0; m_reset(); end
    else if (rel < 2) begin rel++; m_reset(); end
    else begin
      bit ctl, dw, busy;
      ctl  = wr_en && addr;
      dw   = wr_en && !addr;
      busy = 0;
      if (ctl && wdata[5:4] == 2'b11) begin
        m_out = 0; m_arm = 0; m_wsecond = 0; m_rhigh = 0; busy = 1;
      end else if (ctl && wdata[5:4] == 2'b00) begin
        if (!m_held) begin m_held = 1; m_lval = m_cnt; m_rhigh = 0; end
      end
      if (dw) begin
        busy = 1; m_out = 0;
        if (!m_wsecond) begin m_lo = wdata; m_wsecond = 1; m_arm = 0; end
        else begin m_cnt = {wdata, m_lo}; m_wsecond = 0; m_arm = 1; end
      end
      if (!busy && m_arm && gate) begin
        m_cnt = m_cnt - 16'h1;
        if (m_cnt == 16'h0) m_out = 1;
      end
      if (rd_en && !addr && !ctl) begin
        if (m_rhigh) m_held = 0;
        m_rhigh = !m_rhigh;
      end
    end
  end

  task automatic compare();
    logic [15:0] src;
    logic [7:0]  exp;
    src = m_held ? m_lval : m_cnt;
    exp = addr ? 8'h00 : (m_rhigh ? src[15:8] : src[7:0]);
    n_chk++;
    if (out_tc !== m_out) begin
      n_bad++;
      $display("FAIL %s: out_tc actual %b expected %b at %0t", cur_req, out_tc, m_out, $time);
    end
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata actual %h expected %h at %0t", cur_req, rdata, exp, $time);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input bit a, input logic [7:0] d);
    @(negedge clk);
    compare();
    wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00);
  endtask

  task automatic load(input logic [15:0] v);
    cyc(1, 0, 1, 8'h30);
    cyc(1, 0, 0, v[7:0]);
    cyc(1, 0, 0, v[15:8]);
  endtask

  initial begin
    #(10ns * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(2);
    arst_n = 1'b1;
    idle(4);
    cyc(0, 1, 0, 8'h00); cyc(0, 1, 0, 8'h00);
    idle(1);

    cur_req = "R3";
    gate = 1'b1;
    load(16'h0005);
    cur_req = "R4";
    idle(4);
    cur_req = "R6";
    idle(3);
    cur_req = "R7";
    idle(3);
    cyc(0, 1, 0, 8'h00); cyc(0, 1, 0, 8'h00); idle(1);

    cur_req = "R11";
    cyc(1, 0, 1, 8'h10); cyc(1, 0, 1, 8'h20); idle(3);

    cur_req = "R2";
    cyc(1, 0, 1, 8'hF1); idle(3);
    cyc(1, 0, 0, 8'h03); idle(2);

    cur_req = "R5";
    gate = 1'b0;
    load(16'h000A);
    idle(5);
    gate = 1'b1;
    idle(12);

    cur_req = "R8";
    load(16'h1234);
    idle(3);
    cyc(1, 0, 1, 8'h00);
    cur_req = "R9";
    idle(2);
    cyc(1, 0, 1, 8'h00);
    cyc(0, 1, 0, 8'h00);
    idle(3);
    cyc(0, 1, 0, 8'h00);
    idle(1);
    cur_req = "R10";
    cyc(0, 1, 0, 8'h00); idle(1);
    cyc(0, 1, 0, 8'h00); idle(1);
    cyc(0, 1, 0, 8'h00); cyc(1, 0, 1, 8'h30); idle(1);
    cyc(0, 0, 1, 8'h00); idle(1);

    cur_req = "R3";
    load(16'h0002); idle(4);
    cyc(1, 0, 0, 8'h07); idle(3);

    cur_req = "R7";
    cyc(1, 0, 0, 8'h00);
    idle(65540);
    cyc(0, 1, 0, 8'h00); idle(2);

    @(negedge clk);
    compare();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule